// File: doc/BRIEF.md
# Watchdog Timer with Lockable Run Enable

This block is a down-counting watchdog on a zero-wait APB-style register port. A single control bit does two jobs: it enables the interrupt, and it lets the counter run. While that bit is low the count holds. Each `tick_en` pulse moves the count down by one while the bit is high. A tick that arrives while the count is 1 (or 0) is a timeout. On a timeout the count reloads from the load register and a sticky raw status bit sets. If a timeout occurs while raw status is still set from an earlier one, and reset generation is enabled, the block raises a one-cycle reset request.

Register map:

| Offset | Register | Access |
|---|---|---|
| 0x00 | load | read/write |
| 0x04 | live count | read only |
| 0x08 | control | read/write; bit 0 run/interrupt enable, bit 1 reset-request enable |
| 0x0C | clear | write only; any write clears raw status |
| 0x10 | raw status | read only |
| 0x14 | masked status | read only |

Unmapped offsets read as zero.

The build parameter `LOCK_RUN` selects a variant in which control writes are ignored once bit 0 has been set. That bit can then only return to 0 through reset. The asynchronous active-low reset is released synchronously inside the block.

Top module: `wdt_timer`

## Requirements
- R1: After reset, control (0x08) reads 0, raw status (0x10) reads 0, and both load (0x00) and count (0x04) read 0xFFFFFFFF. `irq` and `rst_req` are low.
- R2: While control bit 0 is low, the count at 0x04 holds its value however many tick pulses arrive.
- R3: While control bit 0 is high, each cycle with `tick_en` high lowers the count by exactly one, as long as the count is above 1.
- R4: Writing control bit 0 to 0 stops the count and freezes it at its present value.
- R5: A control write that takes bit 0 from 0 to 1 reloads the count from the load register at once. The count does not resume from the frozen value.
- R6: A write to load (0x00) copies the new value into the count in the same clock edge, whether or not the counter is running. The next read of 0x04 returns that value.
- R7: A tick while running with the count at 1 (or 0) is a timeout: raw status sets and the count reloads from load. While the count is above 1, raw status stays 0, so a count of 1 still shows raw status 0.
- R8: With `LOCK_RUN`=1, every control write made after bit 0 is set is ignored. The counter keeps running, control keeps reading 1, and only reset returns control to 0.
- R9: Masked status (0x14) and the `irq` output both equal raw status AND control bit 0.
- R10: A timeout while raw status is already set and control bit 1 is high asserts `rst_req` for exactly one cycle, on the cycle after that timeout. When control bit 1 is low, no request is made.
- R11: Any write to the clear offset (0x0C) clears raw status and reloads the count from load.
- R12: A reset applied while the counter is running returns all registers to the R1 values, and the counter stays stopped afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count-down strobe, one decrement per high cycle |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase; a write takes effect when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data; combinational while psel is high, otherwise 0 |
| irq | output | 1 | Masked timeout interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A corrupted count shows on the very next read of 0x04. It also moves the timeout, which makes raw status and `irq` rise early or late by the size of the error in ticks. A wrong run-enable or lock state shows within one tick: the count either moves when it should hold or holds when it should move. A raw status that failed to stick shows only at the next timeout, as a missing `rst_req` pulse. For that reason the bench drives two full timeout periods and counts the request pulses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTRL_W = 2;
  localparam int unsigned OFS_LOAD  = 'h00;
  localparam int unsigned OFS_COUNT = 'h04;
  localparam int unsigned OFS_CTRL  = 'h08;
  localparam int unsigned OFS_CLEAR = 'h0C;
  localparam int unsigned OFS_RAW   = 'h10;
  localparam int unsigned OFS_MASK  = 'h14;

  typedef enum logic [2:0] {
    SEL_LOAD, SEL_COUNT, SEL_CTRL, SEL_CLEAR, SEL_RAW, SEL_MASK, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter bit          LOCK_RUN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              raw_st,
  output logic [CNT_W-1:0]  prdata,
  output logic [CNT_W-1:0]  load_q,
  output logic              run_en,
  output logic              rreq_en,
  output logic              load_wr,
  output logic              clr_wr,
  output logic              start
);
  localparam logic [CNT_W-1:0] LOAD_RST = '1;

  reg_sel_e           sel;
  logic               wr_acc;
  logic               ctrl_req;
  logic               ctrl_ok;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [CTRL_W-1:0]  ctrl_d;
  logic [CNT_W-1:0]   load_d;

  always_comb begin
    case (paddr)
      ADDR_W'(OFS_LOAD):  sel = SEL_LOAD;
      ADDR_W'(OFS_COUNT): sel = SEL_COUNT;
      ADDR_W'(OFS_CTRL):  sel = SEL_CTRL;
      ADDR_W'(OFS_CLEAR): sel = SEL_CLEAR;
      ADDR_W'(OFS_RAW):   sel = SEL_RAW;
      ADDR_W'(OFS_MASK):  sel = SEL_MASK;
      default:            sel = SEL_NONE;
    endcase
  end

  assign wr_acc   = psel & penable & pwrite;
  assign load_wr  = wr_acc & (sel == SEL_LOAD);
  assign clr_wr   = wr_acc & (sel == SEL_CLEAR);
  assign ctrl_req = wr_acc & (sel == SEL_CTRL);

  generate
    if (LOCK_RUN) begin : g_lock
      assign ctrl_ok = ctrl_req & ~ctrl_q[0];
    end else begin : g_free
      assign ctrl_ok = ctrl_req;
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    if (ctrl_ok) ctrl_d = pwdata[CTRL_W-1:0];
    if (load_wr) load_d = pwdata;
  end

  assign start = ctrl_ok & pwdata[0] & ~ctrl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= LOAD_RST;
    end else begin
      if (ctrl_ok) ctrl_q <= ctrl_d;
      if (load_wr) load_q <= load_d;
    end
  end

  assign run_en  = ctrl_q[0];
  assign rreq_en = ctrl_q[1];

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (sel)
        SEL_LOAD:  prdata = load_q;
        SEL_COUNT: prdata = cnt_val;
        SEL_CTRL:  prdata = CNT_W'(ctrl_q);
        SEL_RAW:   prdata = CNT_W'(raw_st);
        SEL_MASK:  prdata = CNT_W'(raw_st & ctrl_q[0]);
        default:   prdata = '0;
      endcase
    end
  end

  generate
    if (LOCK_RUN) begin : g_lock_chk
      // R8
      run_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> run_en);
    end
  endgenerate
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr_wr,
  input  logic             start,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] CNT_RST = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             step;

  assign step   = run_en & tick;
  assign cnt_ce = load_wr | clr_wr | start | step;

  always_comb begin
    cnt_d   = cnt_q;
    timeout = 1'b0;
    if (load_wr) begin
      cnt_d = wdata;
    end else if (clr_wr || start) begin
      cnt_d = load_q;
    end else if (step) begin
      if (cnt_q <= ONE) begin
        timeout = 1'b1;
        cnt_d   = load_q;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_RST;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_wr && !clr_wr && !start) |=> $stable(cnt_q));

  // R3
  one_per_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && !load_wr && !clr_wr && !start && cnt_q > ONE)
      |=> cnt_q == $past(cnt_q) - ONE);

  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt_q == $past(wdata));
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic clr_wr,
  input  logic rreq_en,
  output logic raw_q,
  output logic rst_req_q
);
  logic raw_d;
  logic rst_req_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_wr)       raw_d = 1'b0;
    else if (timeout) raw_d = 1'b1;
    rst_req_d = timeout & raw_q & rreq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      raw_q     <= raw_d;
      rst_req_q <= rst_req_d;
    end
  end

  // R7
  raw_from_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(timeout));

  // R10
  req_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> $past(raw_q) && $past(rreq_en));

  // R11
  clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !raw_q);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter bit          LOCK_RUN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [CNT_W-1:0]  pwdata,
  output logic [CNT_W-1:0]  prdata,
  output logic              irq,
  output logic              rst_req
);
  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_en;
  logic             rreq_en;
  logic             load_wr;
  logic             clr_wr;
  logic             start;
  logic             timeout;
  logic             raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  wdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LOCK_RUN(LOCK_RUN)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .cnt_val(cnt_q),
    .raw_st(raw_q), .prdata(prdata), .load_q(load_q), .run_en(run_en),
    .rreq_en(rreq_en), .load_wr(load_wr), .clr_wr(clr_wr), .start(start)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_i_n), .tick(tick_en), .run_en(run_en),
    .load_wr(load_wr), .wdata(pwdata), .clr_wr(clr_wr), .start(start),
    .load_q(load_q), .cnt_q(cnt_q), .timeout(timeout)
  );

  wdt_event u_event (
    .clk(clk), .rst_n(rst_i_n), .timeout(timeout), .clr_wr(clr_wr),
    .rreq_en(rreq_en), .raw_q(raw_q), .rst_req_q(rst_req)
  );

  assign irq = raw_q & run_en;

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !run_en |-> !irq);

  // R5
  start_reload_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start && !load_wr) |=> cnt_q == $past(load_q));
endmodule

// File: tb/test_wdt_timer.sv
`timescale 1ns/1ps
module test_wdt_timer;
  localparam int unsigned CW = 32;
  localparam int unsigned AW = 5;
  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                         A_CLR = 5'h0C, A_RAW = 5'h10, A_MASK = 5'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [CW-1:0] pwdata = '0;
  logic [CW-1:0] prdata_a, prdata_b;
  logic irq_a, irq_b, rr_a, rr_b;

  int n_chk = 0;
  int n_fail = 0;
  int rr_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_timer #(.CNT_W(CW), .ADDR_W(AW), .LOCK_RUN(1'b0)) i_wdt_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel_a),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata_a), .irq(irq_a), .rst_req(rr_a));

  wdt_timer #(.CNT_W(CW), .ADDR_W(AW), .LOCK_RUN(1'b1)) i_wdt_timer_lk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel_b),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata_b), .irq(irq_b), .rst_req(rr_b));

  always @(negedge clk) if (rr_a) rr_cnt++;

  task automatic check(input string tag, input logic [CW-1:0] got,
                       input logic [CW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input bit b, input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    if (b) psel_b = 1'b1; else psel_a = 1'b1;
    pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input bit b, input logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    if (b) psel_b = 1'b1; else psel_a = 1'b1;
    pwrite = 1'b0; paddr = a;
    #1;
    d = b ? prdata_b : prdata_a;
    psel_a = 1'b0; psel_b = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input bit b, input logic [AW-1:0] a,
                        input logic [CW-1:0] exp);
    logic [CW-1:0] v;
    bus_rd(b, a, v);
    check(tag, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_defaults();
    rd_chk("R1 ctrl", 0, A_CTRL, 32'h0);
    rd_chk("R1 raw", 0, A_RAW, 32'h0);
    rd_chk("R1 load", 0, A_LOAD, 32'hFFFF_FFFF);
    rd_chk("R1 count", 0, A_CNT, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq_a}, 32'h0);
    check("R1 rst_req", {31'b0, rr_a}, 32'h0);
  endtask

  task automatic t_stopped();
    ticks(15);
    rd_chk("R2 idle count", 0, A_CNT, 32'hFFFF_FFFF);
    bus_wr(0, A_LOAD, 32'd4000);
    rd_chk("R6 load while stopped", 0, A_CNT, 32'd4000);
    ticks(500);
    rd_chk("R2 held after load", 0, A_CNT, 32'd4000);
  endtask

  task automatic t_run_freeze();
    bus_wr(0, A_CTRL, 32'h1);
    ticks(500);
    rd_chk("R3 decrement", 0, A_CNT, 32'd3500);
    bus_wr(0, A_CTRL, 32'h0);
    ticks(100);
    rd_chk("R4 frozen", 0, A_CNT, 32'd3500);
    bus_wr(0, A_CTRL, 32'h1);
    rd_chk("R5 reload on enable", 0, A_CNT, 32'd4000);
    ticks(50);
    rd_chk("R3 running again", 0, A_CNT, 32'd3950);
    bus_wr(0, A_LOAD, 32'd5000);
    rd_chk("R6 load while running", 0, A_CNT, 32'd5000);
    ticks(4999);
    rd_chk("R7 count at one", 0, A_CNT, 32'd1);
    rd_chk("R7 no timeout at one", 0, A_RAW, 32'h0);
    bus_wr(0, A_CTRL, 32'h0);
    ticks(10);
    rd_chk("R4 frozen at one", 0, A_CNT, 32'd1);
  endtask

  task automatic t_timeout();
    bus_wr(0, A_LOAD, 32'd5);
    bus_wr(0, A_CTRL, 32'h1);
    ticks(4);
    rd_chk("R7 before expiry", 0, A_RAW, 32'h0);
    ticks(1);
    rd_chk("R7 reload on expiry", 0, A_CNT, 32'd5);
    rd_chk("R7 raw set", 0, A_RAW, 32'h1);
    rd_chk("R9 masked set", 0, A_MASK, 32'h1);
    check("R9 irq high", {31'b0, irq_a}, 32'h1);
    rr_cnt = 0;
    ticks(5);
    check("R10 no request when disabled", rr_cnt, 32'd0);
    bus_wr(0, A_CLR, 32'h0);
    rd_chk("R11 raw cleared", 0, A_RAW, 32'h0);
    rd_chk("R11 reload", 0, A_CNT, 32'd5);
  endtask

  task automatic t_request();
    bus_wr(0, A_CTRL, 32'h3);
    rr_cnt = 0;
    ticks(5);
    check("R10 first expiry no request", rr_cnt, 32'd0);
    ticks(5);
    repeat (3) @(negedge clk);
    check("R10 one pulse", rr_cnt, 32'd1);
    check("R10 pulse ended", {31'b0, rr_a}, 32'h0);
    bus_wr(0, A_CTRL, 32'h2);
    rd_chk("R9 raw kept", 0, A_RAW, 32'h1);
    rd_chk("R9 masked gated", 0, A_MASK, 32'h0);
    check("R9 irq gated", {31'b0, irq_a}, 32'h0);
    bus_wr(0, A_CLR, 32'h0);
  endtask

  task automatic t_reset_midrun();
    bus_wr(0, A_LOAD, 32'd3000);
    bus_wr(0, A_CTRL, 32'h1);
    ticks(1000);
    rd_chk("R12 running before reset", 0, A_CNT, 32'd2000);
    do_reset();
    rd_chk("R12 load default", 0, A_LOAD, 32'hFFFF_FFFF);
    rd_chk("R12 count default", 0, A_CNT, 32'hFFFF_FFFF);
    rd_chk("R12 ctrl default", 0, A_CTRL, 32'h0);
    ticks(1000);
    rd_chk("R12 stopped after reset", 0, A_CNT, 32'hFFFF_FFFF);
  endtask

  task automatic t_lock();
    bus_wr(1, A_LOAD, 32'd4000);
    rd_chk("R8 lock load", 1, A_CNT, 32'd4000);
    bus_wr(1, A_CTRL, 32'h1);
    ticks(500);
    rd_chk("R8 lock running", 1, A_CNT, 32'd3500);
    bus_wr(1, A_CTRL, 32'h0);
    ticks(100);
    rd_chk("R8 write ignored keeps running", 1, A_CNT, 32'd3400);
    rd_chk("R8 ctrl stays set", 1, A_CTRL, 32'h1);
    bus_wr(1, A_CTRL, 32'h3);
    rd_chk("R8 ctrl bit1 ignored", 1, A_CTRL, 32'h1);
    do_reset();
    rd_chk("R8 ctrl cleared by reset", 1, A_CTRL, 32'h0);
    ticks(100);
    rd_chk("R8 stopped after reset", 1, A_CNT, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_defaults();
    t_stopped();
    t_run_freeze();
    t_timeout();
    t_request();
    t_reset_midrun();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule